// File: doc/BRIEF.md
# Peripheral Request Router and Channel Arbiter

This block sits between the peripheral request lines of a chip and a bank of DMA channels. A table with one entry per request line says whether the line is in use and which channel it drives. The routed requests, qualified by each channel's busy flag, feed an arbiter. The arbiter hands the shared memory port to one channel at a time through a one-hot grant. It also keeps a registered word with one bit per channel that shows which channels have an interrupt pending.

The arbiter is a two-state machine. In `ARB_IDLE` it looks at the eligible channels. A channel is eligible when it is busy and at least one valid table entry routes an active request to it. Transition `T_START` grants the winner and enters `ARB_HOLD`. The grant then holds for one burst of `BURST_LEN` cycles, and transition `T_BURST_END` returns to `ARB_IDLE`. Transition `T_ABORT` returns early when the owning channel stops being busy. Channel index bits 3:2 give the priority level, and level 0 is the highest. Within one level the grant rotates among the level's members in ascending channel order.

The mapping table is written and read through a simple register port. Lines 0 to 63 sit at byte address 0x0100 + 4·line. Lines 64 and above sit at 0x1100 + 4·(line − 64).

Top module: `dma_req_router`

## Requirements
- R1: A table entry keeps write-data bit 7 as its valid flag and bits 4:0 as its channel number. A read returns exactly those bits in the same positions and zeros elsewhere. Line L < 64 is addressed at 0x0100 + 4·L, and line L ≥ 64 at 0x1100 + 4·(L − 64).
- R2: A write to an address outside both table windows, or with address bits 1:0 non-zero, changes no entry. A read from such an address returns zero.
- R3: A request on a line whose entry has valid clear reaches no channel: the corresponding `chan_req` bit stays low.
- R4: When several valid entries name the same channel, that channel's routed request is the OR of their lines.
- R5: A channel can be granted only while it is busy and has a routed request. `mem_grant` is one-hot, or all zero when no channel is eligible.
- R6: The priority level of a channel is its index bits 3:2, and level 0 wins over all others. Channel 16 beats channel 4, and channel 3 beats channel 12.
- R7: Within one level, members are ordered by ascending channel index. Each new grant goes to the first eligible member after the last one granted in that level, wrapping around. After reset the search starts at the lowest member.
- R8: A grant stays on the same channel for `BURST_LEN` cycles. It is then followed by exactly one cycle with no grant before the next grant.
- R9: If the owning channel's busy input drops during a burst, the grant is removed at the next clock edge.
- R10: `irq_summary` bit c equals `chan_irq` bit c as sampled at the previous clock edge.
- R11: After reset, every table entry is invalid, `mem_grant` is zero and `irq_summary` is zero.
- R12: A table write takes effect from the cycle after the write. An arbitration decision made in the same cycle as the write uses the old entry.
- R13: A channel that stays eligible is granted before any other member of its level is granted a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 16 | Byte address of the table entry |
| cfg_wdata | input | 32 | Write data (bit 7 valid, bits 4:0 channel) |
| cfg_rdata | output | 32 | Read data of the addressed entry (combinational) |
| periph_req | input | NUM_REQ | Request line from each peripheral |
| chan_busy | input | NUM_CH | Channel has work in progress |
| chan_irq | input | NUM_CH | Channel has an interrupt pending |
| chan_req | output | NUM_CH | Routed request per channel |
| mem_grant | output | NUM_CH | One-hot grant of the memory port |
| irq_summary | output | NUM_CH | Registered interrupt summary word |

## Verification
Two functions can land in the same cycle: a table write that retargets a line, and the arbiter sampling that same line in `ARB_IDLE`. The bench provokes this by asserting the request and the remapping write on the same clock edge while every channel is busy. It then requires that the grant goes to the channel the old entry named, and that `chan_req` shows the new channel one cycle later. A second overlap happens when the owner's busy drops in the same cycle that a higher-priority channel becomes eligible. The bench judges that case by seeing the grant fall and then seeing the new winner after one idle cycle.

// File: rtl/dma_rr_pkg.sv
package dma_rr_pkg;

    localparam int ENTRY_VALID_BIT = 7;
    localparam int ENTRY_CHAN_W    = 5;
    localparam int CFG_ADDR_W      = 16;
    localparam int CFG_DATA_W      = 32;
    localparam int NUM_LEVELS      = 4;
    localparam int LINES_PER_BANK  = 64;

    // upper address byte selecting each table window
    localparam logic [7:0] WIN_LO_PAGE = 8'h01;
    localparam logic [7:0] WIN_HI_PAGE = 8'h11;

    typedef enum logic [0:0] {
        ARB_IDLE = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic                    valid;
        logic [ENTRY_CHAN_W-1:0] chan;
    } map_entry_t;

    // channel index of member k of priority level lvl
    function automatic int level_member_chan(input int lvl, input int k);
        return ((k >> 2) << 4) | (lvl << 2) | (k & 3);
    endfunction

    function automatic int chan_level(input int ch);
        return (ch >> 2) & 3;
    endfunction

endpackage

// File: rtl/rr_map_table.sv
module rr_map_table
    import dma_rr_pkg::*;
#(
    parameter int NUM_REQ = 128,
    parameter int NUM_CH  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    output logic [CFG_DATA_W-1:0] cfg_rdata,
    input  logic [NUM_REQ-1:0]    periph_req,
    output logic [NUM_CH-1:0]     chan_req
);

    localparam int LINE_W = $clog2(NUM_REQ);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam logic [ENTRY_CHAN_W:0] CH_LIMIT = NUM_CH[ENTRY_CHAN_W:0];

    map_entry_t          tbl_q [NUM_REQ];
    logic                hit;
    logic [LINE_W-1:0]   line_sel;

    // address decode: two windows of 64 word-aligned entries
    always_comb begin
        int line_i;
        hit    = 1'b0;
        line_i = 0;
        if (cfg_addr[1:0] == 2'b00) begin
            if (cfg_addr[15:8] == WIN_LO_PAGE) begin
                line_i = int'(cfg_addr[7:2]);
                hit    = 1'b1;
            end else if (cfg_addr[15:8] == WIN_HI_PAGE) begin
                line_i = LINES_PER_BANK + int'(cfg_addr[7:2]);
                hit    = 1'b1;
            end
        end
        if (line_i >= NUM_REQ) begin
            hit = 1'b0;
        end
        line_sel = LINE_W'(line_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REQ; r++) begin
                tbl_q[r] <= '0;
            end
        end else if (cfg_we && hit) begin
            tbl_q[line_sel].valid <= cfg_wdata[ENTRY_VALID_BIT];
            tbl_q[line_sel].chan  <= cfg_wdata[ENTRY_CHAN_W-1:0];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (hit) begin
            cfg_rdata[ENTRY_VALID_BIT]    = tbl_q[line_sel].valid;
            cfg_rdata[ENTRY_CHAN_W-1:0]   = tbl_q[line_sel].chan;
        end
    end

    // routing: each valid line ORs its request into its channel
    always_comb begin
        chan_req = '0;
        for (int r = 0; r < NUM_REQ; r++) begin
            if (tbl_q[r].valid && periph_req[r] &&
                ({1'b0, tbl_q[r].chan} < CH_LIMIT)) begin
                chan_req[tbl_q[r].chan[CH_W-1:0]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rr_level_pick.sv
module rr_level_pick #(
    parameter int MEMBERS = 8
) (
    input  logic [MEMBERS-1:0]         elig,
    input  logic [$clog2(MEMBERS)-1:0] last,
    output logic                       found,
    output logic [$clog2(MEMBERS)-1:0] pick
);

    localparam int MB_W = $clog2(MEMBERS);

    // search starts just after the last granted member and wraps
    always_comb begin
        found = 1'b0;
        pick  = last;
        for (int i = 1; i <= MEMBERS; i++) begin
            logic [MB_W-1:0] pos;
            pos = MB_W'((int'(last) + i) % MEMBERS);
            if (!found && elig[pos]) begin
                found = 1'b1;
                pick  = pos;
            end
        end
    end

endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
    import dma_rr_pkg::*;
#(
    parameter int NUM_CH    = 32,
    parameter int NUM_REQ   = 128,
    parameter int BURST_LEN = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    output logic [CFG_DATA_W-1:0] cfg_rdata,
    input  logic [NUM_REQ-1:0]    periph_req,
    input  logic [NUM_CH-1:0]     chan_busy,
    input  logic [NUM_CH-1:0]     chan_irq,
    output logic [NUM_CH-1:0]     chan_req,
    output logic [NUM_CH-1:0]     mem_grant,
    output logic [NUM_CH-1:0]     irq_summary
);

    localparam int MEMBERS = NUM_CH / NUM_LEVELS;
    localparam int MB_W    = $clog2(MEMBERS);
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int CNT_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    logic [NUM_CH-1:0] chan_req_w;
    logic [NUM_CH-1:0] elig_w;

    rr_map_table #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH)
    ) map_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .periph_req (periph_req),
        .chan_req   (chan_req_w)
    );

    assign elig_w   = chan_req_w & chan_busy;
    assign chan_req = chan_req_w;

    // ---------------- per-level round-robin pickers ----------------
    logic [MB_W-1:0] ptr_q     [NUM_LEVELS];
    logic [MB_W-1:0] lvl_pick  [NUM_LEVELS];
    logic            lvl_found [NUM_LEVELS];

    for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
        logic [MEMBERS-1:0] members;
        for (genvar k = 0; k < MEMBERS; k++) begin : g_member
            assign members[k] = elig_w[level_member_chan(lv, k)];
        end
        rr_level_pick #(
            .MEMBERS (MEMBERS)
        ) pick_i (
            .elig  (members),
            .last  (ptr_q[lv]),
            .found (lvl_found[lv]),
            .pick  (lvl_pick[lv])
        );
    end

    // ---------------- fixed priority across levels ----------------
    logic            sel_valid;
    logic [1:0]      sel_lvl;
    logic [MB_W-1:0] sel_member;
    logic [CH_W-1:0] sel_chan;

    always_comb begin
        sel_valid  = 1'b0;
        sel_lvl    = '0;
        sel_member = '0;
        for (int lv = NUM_LEVELS - 1; lv >= 0; lv--) begin
            if (lvl_found[lv]) begin
                sel_valid  = 1'b1;
                sel_lvl    = 2'(lv);
                sel_member = lvl_pick[lv];
            end
        end
        sel_chan = CH_W'(level_member_chan(int'(sel_lvl), int'(sel_member)));
    end

    // ---------------- grant state machine ----------------
    arb_state_e         state_q, state_d;
    logic [NUM_CH-1:0]  gnt_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               burst_end;
    logic               owner_busy;

    assign burst_end  = (cnt_q == CNT_W'(BURST_LEN - 1));
    assign owner_busy = |(gnt_q & chan_busy);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (sel_valid) begin
                    state_d = ARB_HOLD;          // T_START
                end
            end
            ARB_HOLD: begin
                if (burst_end || !owner_busy) begin
                    state_d = ARB_IDLE;          // T_BURST_END / T_ABORT
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q <= '0;
            cnt_q <= '0;
            for (int lv = 0; lv < NUM_LEVELS; lv++) begin
                ptr_q[lv] <= MB_W'(MEMBERS - 1);
            end
        end else begin
            unique case (state_q)
                ARB_IDLE: begin
                    if (sel_valid) begin
                        gnt_q          <= NUM_CH'(1) << sel_chan;
                        cnt_q          <= '0;
                        ptr_q[sel_lvl] <= sel_member;
                    end
                end
                ARB_HOLD: begin
                    if (state_d == ARB_IDLE) begin
                        gnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign mem_grant = gnt_q;

    // ---------------- interrupt summary ----------------
    logic [NUM_CH-1:0] irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= chan_irq;
        end
    end

    assign irq_summary = irq_q;

endmodule

// File: rtl/dma_req_router_chk.sv
module dma_req_router_chk
    import dma_rr_pkg::*;
#(
    parameter int NUM_CH    = 32,
    parameter int BURST_LEN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] mem_grant,
    input logic [NUM_CH-1:0] chan_busy,
    input logic [NUM_CH-1:0] chan_irq,
    input logic [NUM_CH-1:0] irq_summary,
    input logic [NUM_CH-1:0] elig
);

    localparam int MEMBERS = NUM_CH / NUM_LEVELS;

    logic [NUM_CH-1:0] gnt_d, elig_d, irq_d;
    logic [15:0]       hold_q;
    logic [7:0]        starve_q [NUM_CH];
    logic              start;
    int                g_lvl, min_lvl, run_len;

    assign start = (|mem_grant) && !(|gnt_d);

    always_comb begin
        g_lvl   = 0;
        min_lvl = NUM_LEVELS;
        for (int c = 0; c < NUM_CH; c++) begin
            if (mem_grant[c]) g_lvl = chan_level(c);
            if (elig_d[c] && chan_level(c) < min_lvl) min_lvl = chan_level(c);
        end
        run_len = start ? 1 : int'(hold_q) + 1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_d  <= '0;
            elig_d <= '0;
            irq_d  <= '0;
            hold_q <= '0;
            for (int c = 0; c < NUM_CH; c++) starve_q[c] <= '0;
        end else begin
            gnt_d  <= mem_grant;
            elig_d <= elig;
            irq_d  <= chan_irq;
            hold_q <= (|mem_grant) ? 16'(run_len) : 16'd0;
            for (int c = 0; c < NUM_CH; c++) begin
                if (start) begin
                    if (mem_grant[c] || !elig_d[c])
                        starve_q[c] <= '0;
                    else if (chan_level(c) == g_lvl)
                        starve_q[c] <= starve_q[c] + 8'd1;
                end else if (!elig[c]) begin
                    starve_q[c] <= '0;
                end
            end
        end
    end

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_grant));

    assert_grant_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ((mem_grant & elig_d) != '0));

    assert_level_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (g_lvl <= min_lvl));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt_d) && (|mem_grant)) |-> (mem_grant == gnt_d));

    assert_burst_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_grant) |-> (run_len <= BURST_LEN));

    assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_grant & ~chan_busy) != '0) |=> (mem_grant == '0));

    assert_irq_summary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_summary == irq_d);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_starve
        assert_no_starve_R13: assert property (@(posedge clk) disable iff (!rst_n)
            int'(starve_q[c]) < MEMBERS);
    end

endmodule

bind dma_req_router dma_req_router_chk #(
    .NUM_CH    (NUM_CH),
    .BURST_LEN (BURST_LEN)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_grant   (mem_grant),
    .chan_busy   (chan_busy),
    .chan_irq    (chan_irq),
    .irq_summary (irq_summary),
    .elig        (elig_w)
);

// File: tb/dma_req_router_tb_top.sv
module dma_req_router_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 32;
    localparam int NUM_REQ    = 128;
    localparam int BURST_LEN  = 4;
    localparam int NUM_VEC    = 8;
    localparam logic [31:0] LVL0_MASK = 32'h000F_000F;

    // vector: {line[6:0], valid, chan[4:0], addr[15:0]}
    localparam logic [28:0] VEC [NUM_VEC] = '{
        {7'd0,   1'b1, 5'd2,  16'h0100},
        {7'd3,   1'b1, 5'd9,  16'h010C},
        {7'd63,  1'b1, 5'd31, 16'h01FC},
        {7'd64,  1'b1, 5'd0,  16'h1100},
        {7'd65,  1'b0, 5'd7,  16'h1104},
        {7'd127, 1'b1, 5'd17, 16'h11FC},
        {7'd10,  1'b0, 5'd12, 16'h0128},
        {7'd70,  1'b1, 5'd30, 16'h1118}
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               cfg_we;
    logic [15:0]        cfg_addr;
    logic [31:0]        cfg_wdata;
    logic [31:0]        cfg_rdata;
    logic [NUM_REQ-1:0] periph_req;
    logic [NUM_CH-1:0]  chan_busy, chan_irq, chan_req, mem_grant, irq_summary;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_req_router #(
        .NUM_CH    (NUM_CH),
        .NUM_REQ   (NUM_REQ),
        .BURST_LEN (BURST_LEN)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .periph_req  (periph_req),
        .chan_busy   (chan_busy),
        .chan_irq    (chan_irq),
        .chan_req    (chan_req),
        .mem_grant   (mem_grant),
        .irq_summary (irq_summary)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n      = 1'b0;
        cfg_we     = 1'b0;
        cfg_addr   = '0;
        cfg_wdata  = '0;
        periph_req = '0;
        chan_busy  = '0;
        chan_irq   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] addr, input logic [31:0] data);
        cfg_we    = 1'b1;
        cfg_addr  = addr;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic rd_check(input logic [15:0] addr, input logic [31:0] exp, input string tag);
        cfg_addr = addr;
        #1;
        check(cfg_rdata === exp, tag, cfg_rdata, exp);
    endtask

    task automatic map_identity();
        for (int c = 0; c < NUM_CH; c++) begin
            wr(16'h0100 + 16'(4 * c), 32'h80 | 32'(c));
        end
        periph_req = '0;
        periph_req[NUM_CH-1:0] = '1;
    endtask

    task automatic next_grant(output logic [NUM_CH-1:0] g);
        int n = 0;
        while (mem_grant != '0 && n < 50) begin @(negedge clk); n++; end
        while (mem_grant == '0 && n < 50) begin @(negedge clk); n++; end
        g = mem_grant;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NUM_CH-1:0] g;
        logic [NUM_CH-1:0] seen;
        int hi_cnt, lo_cnt;

        // ---- R11: reset state
        do_reset();
        periph_req = '1;
        chan_busy  = '1;
        repeat (2) @(negedge clk);
        check(mem_grant == '0, "R11 grant after reset", mem_grant, 0);
        check(chan_req == '0, "R11 all entries invalid", chan_req, 0);
        check(irq_summary == '0, "R11 summary after reset", irq_summary, 0);
        rd_check(16'h0100, 32'h0, "R11 entry reads zero");
        periph_req = '0;
        chan_busy  = '0;

        // ---- R1 / R3: vector table of entry writes
        for (int i = 0; i < NUM_VEC; i++) begin
            logic [6:0]  line;
            logic        vld;
            logic [4:0]  ch;
            logic [15:0] addr;
            logic [31:0] exp_rd;
            logic [31:0] exp_req;
            {line, vld, ch, addr} = VEC[i];
            wr(addr, {24'hFFFFFF, vld, 2'b11, ch});
            exp_rd = {24'h0, vld, 2'b00, ch};
            rd_check(addr, exp_rd, "R1 entry readback");
            periph_req = '0;
            periph_req[line] = 1'b1;
            #1;
            exp_req = vld ? (32'h1 << ch) : 32'h0;
            check(chan_req == exp_req, vld ? "R1 routing" : "R3 invalid line ignored",
                  chan_req, exp_req);
        end
        periph_req = '0;

        // ---- R2: writes outside the windows or misaligned
        wr(16'h0300, 32'h85);
        rd_check(16'h0300, 32'h0, "R2 out-of-window read");
        wr(16'h0102, 32'h9F);
        rd_check(16'h0100, 32'h82, "R2 misaligned write ignored");
        wr(16'h1300, 32'h83);
        periph_req = '1;
        #1;
        check(chan_req[3] == 1'b0, "R2 no stray route", chan_req, 0);
        periph_req = '0;

        // ---- R4: two lines on one channel
        wr(16'h0100 + 16'(4 * 20), 32'h85);
        wr(16'h0100 + 16'(4 * 21), 32'h85);
        periph_req = '0; periph_req[20] = 1'b1; #1;
        check(chan_req == 32'h20, "R4 first line", chan_req, 32'h20);
        periph_req = '0; periph_req[21] = 1'b1; #1;
        check(chan_req == 32'h20, "R4 second line", chan_req, 32'h20);
        periph_req = '0;

        // ---- R7 / R13: rotation inside level 0
        do_reset();
        map_identity();
        chan_busy = 32'h0001_0003;
        next_grant(g); check(g == 32'h1, "R7 first grant ch0", g, 32'h1);
        next_grant(g); check(g == 32'h2, "R7 second grant ch1", g, 32'h2);
        next_grant(g); check(g == 32'h0001_0000, "R7 third grant ch16", g, 32'h0001_0000);
        next_grant(g); check(g == 32'h1, "R7 wrap to ch0", g, 32'h1);
        chan_busy = LVL0_MASK;
        seen = '0;
        for (int n = 0; n < 8; n++) begin
            next_grant(g);
            check((seen & g) == '0, "R13 no member twice", seen & g, 0);
            seen |= g;
        end
        check(seen == LVL0_MASK, "R13 every member served", seen, LVL0_MASK);

        // ---- R6: fixed priority across levels
        chan_busy = 32'h0001_0010;
        next_grant(g);
        if (g == 32'h0001_0010 & 32'h0001_0000) ; else ;
        next_grant(g); check(g == 32'h0001_0000, "R6 ch16 beats ch4", g, 32'h0001_0000);
        chan_busy = 32'h0000_1008;
        next_grant(g); check(g == 32'h8, "R6 ch3 beats ch12", g, 32'h8);

        // ---- R5: no grant without busy
        chan_busy = '0;
        repeat (BURST_LEN + 3) @(negedge clk);
        check(mem_grant == '0, "R5 idle when nothing busy", mem_grant, 0);

        // ---- R8: burst length and idle gap
        chan_busy = 32'h20;
        while (mem_grant == '0) @(negedge clk);
        hi_cnt = 0;
        while (mem_grant != '0 && hi_cnt < 20) begin hi_cnt++; @(negedge clk); end
        lo_cnt = 0;
        while (mem_grant == '0 && lo_cnt < 20) begin lo_cnt++; @(negedge clk); end
        check(hi_cnt == BURST_LEN, "R8 burst length", hi_cnt, BURST_LEN);
        check(lo_cnt == 1, "R8 single idle cycle", lo_cnt, 1);

        // ---- R9: early release when owner goes idle
        chan_busy = '0;
        repeat (BURST_LEN + 2) @(negedge clk);
        chan_busy = 32'h40;
        while (mem_grant == '0) @(negedge clk);
        chan_busy = '0;
        @(negedge clk);
        check(mem_grant == '0, "R9 grant dropped", mem_grant, 0);

        // ---- R10: interrupt summary register
        chan_irq = 32'hA5A5_0003;
        #1;
        check(irq_summary == '0, "R10 summary not yet updated", irq_summary, 0);
        @(negedge clk);
        check(irq_summary == 32'hA5A5_0003, "R10 summary follows", irq_summary, 32'hA5A5_0003);
        chan_irq = 32'h8000_0000;
        @(negedge clk);
        check(irq_summary == 32'h8000_0000, "R10 summary update", irq_summary, 32'h8000_0000);

        // ---- R12: remap write in the same cycle as arbitration
        do_reset();
        wr(16'h0100 + 16'(4 * 40), 32'h88);
        chan_busy = '1;
        @(negedge clk);
        periph_req[40] = 1'b1;
        cfg_we    = 1'b1;
        cfg_addr  = 16'h0100 + 16'(4 * 40);
        cfg_wdata = 32'h89;
        @(negedge clk);
        cfg_we = 1'b0;
        check(mem_grant == 32'h100, "R12 grant uses old entry", mem_grant, 32'h100);
        check(chan_req == 32'h200, "R12 new entry next cycle", chan_req, 32'h200);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule